// File: doc/BRIEF.md
# Two-Master Bus Arbiter and Address Decoder

This block is the central controller of an on-chip peripheral bus that two masters share: a processor interface (port prefix `cpu_`) and a display controller (port prefix `dsp_`). Each master issues 32-bit read or write transfers to word addresses. A master raises its request together with the direction, the address and the write data, and holds all of them until it sees its acknowledge at a clock edge. When both masters want the bus at once, a rotating priority picks the winner. The winner keeps the bus until the targeted slave acknowledges.

While it owns the bus, the winner's strobes, address and write data are steered onto one shared slave-side bus. The address is decoded into a one-hot select over a parameterised number of register peripherals plus one memory window. The selected slave's acknowledge and read data are steered back to the owner only. An address that matches no region is acknowledged by the block itself, with zero read data, so that no master waits forever.

Top module: `busctl_top`

## Requirements
- R1: While reset is held and after it is released with no request, every slave select, `s_rd_o`, `s_wr_o`, `cpu_ack_o` and `dsp_ack_o` are low.
- R2: When only one master requests and the bus is idle, its transfer is presented to the slaves in the next cycle, whatever the rotation state.
- R3: When both masters request at the same time for the first time after reset, the processor interface is served first.
- R4: When both masters request together, the master that was granted least recently is served first.
- R5: Once granted, a master keeps the bus until the targeted slave acknowledges. The select and strobes stay stable until then, and the other master's transfer can be presented no earlier than two cycles after that acknowledge.
- R6: An address whose byte bits [31:8] equal `REG_PAGE` and whose bits [7:4] hold an index k below `NREG` asserts only select bit k, and drives `s_reg_addr_o` with address bits [3:2].
- R7: An address whose bits [31:22] equal `MEM_TAG` asserts only select bit `NREG` (the top bit), and drives `s_mem_addr_o` with address bits [21:2].
- R8: An address that matches no region asserts no select. The block acknowledges it in the first cycle of ownership with read data zero.
- R9: The acknowledge and read data reach only the master that owns the bus. The other master's acknowledge stays low and its read data reads zero.
- R10: `s_rd_o` (read) or `s_wr_o` (write) follows the owner's direction, and `s_wdata_o` carries the owner's write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor interface requests a transfer |
| cpu_we_i | input | 1 | Processor transfer is a write (1) or a read (0) |
| cpu_addr_i | input | 30 | Processor word address, bits 31:2 |
| cpu_wdata_i | input | DW | Processor write data |
| cpu_ack_o | output | 1 | Processor transfer completes at this edge |
| cpu_rdata_o | output | DW | Processor read data, valid with its acknowledge |
| dsp_req_i | input | 1 | Display controller requests a transfer |
| dsp_we_i | input | 1 | Display transfer is a write (1) or a read (0) |
| dsp_addr_i | input | 30 | Display word address, bits 31:2 |
| dsp_wdata_i | input | DW | Display write data |
| dsp_ack_o | output | 1 | Display transfer completes at this edge |
| dsp_rdata_o | output | DW | Display read data, valid with its acknowledge |
| s_sel_o | output | NREG+1 | One-hot slave select; the top bit is the memory window |
| s_rd_o | output | 1 | Read strobe to the selected slave |
| s_wr_o | output | 1 | Write strobe to the selected slave |
| s_reg_addr_o | output | 2 | Word index inside a register peripheral |
| s_mem_addr_o | output | MEM_AW | Word address inside the memory window |
| s_wdata_o | output | DW | Write data to the slaves |
| s_ack_i | input | NREG+1 | Per-slave acknowledge |
| s_rdata_i | input | (NREG+1)*DW | Per-slave read data, slave k at bits k*DW upward |

## Verification
A request applied between edges appears on the slave side one edge later, because the grant is registered. A slave acknowledge reaches the owner in the same cycle with no register on the way. An unmapped access therefore completes one cycle after its request, and a one-wait-state slave completes after two. The loser of a contention needs one cycle to release the bus and one to be granted again, so it completes three cycles after the winner. Every check samples at the falling edge, numbered from the falling edge where the request was driven, and compares against these latencies and against the snapshot taken in the first cycle of ownership.

// File: rtl/busctl_pkg.sv
package busctl_pkg;
  typedef enum logic {
    MST_CPU = 1'b0,
    MST_DSP = 1'b1
  } mst_e;

  localparam int unsigned NUM_MST = 2;
endpackage

// File: rtl/busctl_arb.sv
module busctl_arb
  import busctl_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_MST-1:0]  req_i,
  input  logic                done_i,
  output logic                busy_o,
  output mst_e                owner_o
);
  logic busy_q;
  mst_e owner_q, last_q, win;

  // rotating priority: the master granted last loses a tie
  always_comb begin
    if (req_i[MST_CPU] && req_i[MST_DSP]) begin
      win = (last_q == MST_CPU) ? MST_DSP : MST_CPU;
    end else if (req_i[MST_DSP]) begin
      win = MST_DSP;
    end else begin
      win = MST_CPU;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      owner_q <= MST_CPU;
      last_q  <= MST_DSP;  // favours the processor after reset
    end else if (!busy_q) begin
      if (|req_i) begin
        busy_q  <= 1'b1;
        owner_q <= win;
        last_q  <= win;
      end
    end else if (done_i) begin
      busy_q <= 1'b0;
    end
  end

  assign busy_o  = busy_q;
  assign owner_o = owner_q;
endmodule

// File: rtl/busctl_dec.sv
module busctl_dec #(
  parameter int unsigned          NREG     = 4,
  parameter int unsigned          MEM_AW   = 20,
  parameter logic [23:0]          REG_PAGE = 24'h80_0000,
  parameter int unsigned          MEM_TAG  = 1
) (
  input  logic            busy_i,
  input  logic [31:2]     addr_i,
  output logic [NREG:0]   sel_o,
  output logic            miss_o
);
  localparam int unsigned TAG_W = 30 - MEM_AW;

  logic [NREG:0] hit;
  logic          page_hit;

  assign page_hit = (addr_i[31:8] == REG_PAGE);

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    assign hit[k] = page_hit && (addr_i[7:4] == 4'(k));
  end

  assign hit[NREG] = (addr_i[31:2+MEM_AW] == TAG_W'(MEM_TAG));

  assign sel_o  = busy_i ? hit : '0;
  assign miss_o = busy_i && !(|hit);
endmodule

// File: rtl/busctl_rsp.sv
module busctl_rsp
  import busctl_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned NS = 5
) (
  input  mst_e              owner_i,
  input  logic [NS-1:0]     sel_i,
  input  logic              miss_i,
  input  logic [NS-1:0]     s_ack_i,
  input  logic [NS*DW-1:0]  s_rdata_i,
  output logic              done_o,
  output logic              cpu_ack_o,
  output logic [DW-1:0]     cpu_rdata_o,
  output logic              dsp_ack_o,
  output logic [DW-1:0]     dsp_rdata_o
);
  logic [DW-1:0] part [NS];
  logic [DW-1:0] rdata;
  logic          ack;

  for (genvar k = 0; k < NS; k++) begin : g_mux
    assign part[k] = sel_i[k] ? s_rdata_i[k*DW +: DW] : '0;
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NS; k++) rdata |= part[k];
  end

  // unmapped access completes at once with zero data
  assign ack    = (|(sel_i & s_ack_i)) || miss_i;
  assign done_o = ack;

  assign cpu_ack_o   = ack && (owner_i == MST_CPU);
  assign dsp_ack_o   = ack && (owner_i == MST_DSP);
  assign cpu_rdata_o = cpu_ack_o ? rdata : '0;
  assign dsp_rdata_o = dsp_ack_o ? rdata : '0;
endmodule

// File: rtl/busctl_top.sv
module busctl_top
  import busctl_pkg::*;
#(
  parameter int unsigned DW       = 32,
  parameter int unsigned NREG     = 4,
  parameter int unsigned MEM_AW   = 20,
  parameter logic [23:0] REG_PAGE = 24'h80_0000,
  parameter int unsigned MEM_TAG  = 1,
  localparam int unsigned NS      = NREG + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [31:2]       cpu_addr_i,
  input  logic [DW-1:0]     cpu_wdata_i,
  output logic              cpu_ack_o,
  output logic [DW-1:0]     cpu_rdata_o,
  input  logic              dsp_req_i,
  input  logic              dsp_we_i,
  input  logic [31:2]       dsp_addr_i,
  input  logic [DW-1:0]     dsp_wdata_i,
  output logic              dsp_ack_o,
  output logic [DW-1:0]     dsp_rdata_o,
  output logic [NS-1:0]     s_sel_o,
  output logic              s_rd_o,
  output logic              s_wr_o,
  output logic [1:0]        s_reg_addr_o,
  output logic [MEM_AW-1:0] s_mem_addr_o,
  output logic [DW-1:0]     s_wdata_o,
  input  logic [NS-1:0]     s_ack_i,
  input  logic [NS*DW-1:0]  s_rdata_i
);
  logic          busy, done, miss;
  mst_e          owner;
  logic          o_we;
  logic [31:2]   o_addr;
  logic [DW-1:0] o_wdata;

  busctl_arb u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   ({dsp_req_i, cpu_req_i}),
    .done_i  (done),
    .busy_o  (busy),
    .owner_o (owner)
  );

  // master-side control mux
  always_comb begin
    if (owner == MST_DSP) begin
      o_we    = dsp_we_i;
      o_addr  = dsp_addr_i;
      o_wdata = dsp_wdata_i;
    end else begin
      o_we    = cpu_we_i;
      o_addr  = cpu_addr_i;
      o_wdata = cpu_wdata_i;
    end
  end

  busctl_dec #(
    .NREG     (NREG),
    .MEM_AW   (MEM_AW),
    .REG_PAGE (REG_PAGE),
    .MEM_TAG  (MEM_TAG)
  ) u_dec (
    .busy_i (busy),
    .addr_i (o_addr),
    .sel_o  (s_sel_o),
    .miss_o (miss)
  );

  busctl_rsp #(
    .DW (DW),
    .NS (NS)
  ) u_rsp (
    .owner_i     (owner),
    .sel_i       (s_sel_o),
    .miss_i      (miss),
    .s_ack_i     (s_ack_i),
    .s_rdata_i   (s_rdata_i),
    .done_o      (done),
    .cpu_ack_o   (cpu_ack_o),
    .cpu_rdata_o (cpu_rdata_o),
    .dsp_ack_o   (dsp_ack_o),
    .dsp_rdata_o (dsp_rdata_o)
  );

  assign s_rd_o       = busy && !o_we;
  assign s_wr_o       = busy && o_we;
  assign s_reg_addr_o = o_addr[3:2];
  assign s_mem_addr_o = o_addr[2 +: MEM_AW];
  assign s_wdata_o    = busy ? o_wdata : '0;
endmodule

// File: rtl/busctl_chk.sv
module busctl_chk #(
  parameter int unsigned NS = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cpu_req_i,
  input logic          dsp_req_i,
  input logic          cpu_ack_o,
  input logic          dsp_ack_o,
  input logic [NS-1:0] s_sel_o,
  input logic          s_rd_o,
  input logic          s_wr_o
);
  logic act, ack;
  assign act = s_rd_o || s_wr_o;
  assign ack = cpu_ack_o || dsp_ack_o;

  p_sel_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(s_sel_o));

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act |-> (s_sel_o == '0) && !ack);

  p_strobe_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(s_rd_o && s_wr_o));

  p_ack_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cpu_ack_o && dsp_ack_o));

  p_grant_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act && (cpu_req_i || dsp_req_i)) |=> act);

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && !ack) |=> act && $stable(s_sel_o) && $stable(s_wr_o));

  p_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack |=> !act);

  p_miss_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && (s_sel_o == '0)) |-> ack);
endmodule

bind busctl_top busctl_chk #(.NS(NS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cpu_req_i (cpu_req_i),
  .dsp_req_i (dsp_req_i),
  .cpu_ack_o (cpu_ack_o),
  .dsp_ack_o (dsp_ack_o),
  .s_sel_o   (s_sel_o),
  .s_rd_o    (s_rd_o),
  .s_wr_o    (s_wr_o)
);

// File: tb/busctl_top_tb_top.sv
module busctl_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int NREG = 4;
  localparam int NS = NREG + 1;
  localparam int MEM_AW = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              cpu_req = 0, cpu_we = 0, dsp_req = 0, dsp_we = 0;
  logic [31:2]       cpu_addr = '0, dsp_addr = '0;
  logic [DW-1:0]     cpu_wdata = '0, dsp_wdata = '0;
  logic              cpu_ack, dsp_ack, s_rd, s_wr;
  logic [DW-1:0]     cpu_rdata, dsp_rdata, s_wdata;
  logic [NS-1:0]     s_sel, s_ack, wait_q;
  logic [1:0]        s_reg_addr;
  logic [MEM_AW-1:0] s_mem_addr;
  logic [NS*DW-1:0]  s_rdata;

  busctl_top dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_ack_o(cpu_ack), .cpu_rdata_o(cpu_rdata),
    .dsp_req_i(dsp_req), .dsp_we_i(dsp_we), .dsp_addr_i(dsp_addr),
    .dsp_wdata_i(dsp_wdata), .dsp_ack_o(dsp_ack), .dsp_rdata_o(dsp_rdata),
    .s_sel_o(s_sel), .s_rd_o(s_rd), .s_wr_o(s_wr), .s_reg_addr_o(s_reg_addr),
    .s_mem_addr_o(s_mem_addr), .s_wdata_o(s_wdata), .s_ack_i(s_ack),
    .s_rdata_i(s_rdata)
  );

  // slave models: one wait state, register files and a small memory
  logic [DW-1:0] regs [NREG][4];
  logic [DW-1:0] mem [16];

  assign s_ack = s_sel & wait_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= '0;
      for (int k = 0; k < NREG; k++)
        for (int w = 0; w < 4; w++) regs[k][w] <= {16'hBEEF, 8'(k), 8'(w)};
      for (int m = 0; m < 16; m++) mem[m] <= '0;
    end else begin
      wait_q <= s_sel & ~s_ack;
      if (s_wr) begin
        for (int k = 0; k < NREG; k++)
          if (s_ack[k]) regs[k][s_reg_addr] <= s_wdata;
        if (s_ack[NREG]) mem[s_mem_addr[3:0]] <= s_wdata;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < NREG; k++) s_rdata[k*DW +: DW] = regs[k][s_reg_addr];
    s_rdata[NREG*DW +: DW] = mem[s_mem_addr[3:0]];
  end

  int total = 0, bad = 0;
  logic finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // snapshot of the slave side in the first cycle of ownership
  logic [NS-1:0]     sn_sel;
  logic              sn_rd, sn_wr, oth_ack;
  logic [1:0]        sn_reg;
  logic [MEM_AW-1:0] sn_mem;
  logic [DW-1:0]     sn_wd, oth_rd;

  task automatic drive(input int m, input logic rq, input logic we,
                       input logic [31:0] ba, input logic [31:0] wd);
    if (m == 0) begin
      cpu_req = rq; cpu_we = we; cpu_addr = ba[31:2]; cpu_wdata = wd;
    end else begin
      dsp_req = rq; dsp_we = we; dsp_addr = ba[31:2]; dsp_wdata = wd;
    end
  endtask

  task automatic do_xfer(input int m, input logic we, input logic [31:0] ba,
                         input logic [31:0] wd, output logic [31:0] rd, output int lat);
    @(negedge clk);
    drive(m, 1'b1, we, ba, wd);
    lat = 0; rd = '0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (i == 1) begin
        sn_sel = s_sel; sn_rd = s_rd; sn_wr = s_wr;
        sn_reg = s_reg_addr; sn_mem = s_mem_addr; sn_wd = s_wdata;
      end
      if ((m == 0) ? cpu_ack : dsp_ack) begin
        lat = i;
        rd = (m == 0) ? cpu_rdata : dsp_rdata;
        oth_ack = (m == 0) ? dsp_ack : cpu_ack;
        oth_rd = (m == 0) ? dsp_rdata : cpu_rdata;
        break;
      end
    end
    @(negedge clk);
    drive(m, 1'b0, 1'b0, 32'h0, 32'h0);
  endtask

  task automatic t_reset();
    rst_ni = 0;
    repeat (3) @(negedge clk);
    chk("R1 sel in reset", 32'(s_sel), 32'h0);
    chk("R1 strobes in reset", {30'h0, s_rd, s_wr}, 32'h0);
    rst_ni = 1;
    repeat (2) @(negedge clk);
    chk("R1 sel idle", 32'(s_sel), 32'h0);
    chk("R1 acks idle", {30'h0, cpu_ack, dsp_ack}, 32'h0);
  endtask

  // both read: cpu slave0 word0, display slave1 word3
  task automatic t_contend(input int first, input string tag);
    int ct = 0, dt = 0;
    logic both = 0;
    logic [31:0] crd = '0, drd = '0, lose_rd = '0;
    @(negedge clk);
    drive(0, 1'b1, 1'b0, 32'h8000_0000, 32'h0);
    drive(1, 1'b1, 1'b0, 32'h8000_001C, 32'h0);
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (ct > 0) cpu_req = 0;
      if (dt > 0) dsp_req = 0;
      #1;
      if (cpu_ack && dsp_ack) both = 1;
      if (cpu_ack && ct == 0) begin ct = i; crd = cpu_rdata; if (first == 0) lose_rd = dsp_rdata; end
      if (dsp_ack && dt == 0) begin dt = i; drd = dsp_rdata; if (first == 1) lose_rd = cpu_rdata; end
    end
    chk({tag, " winner latency"}, (first == 0) ? ct : dt, 2);
    chk("R5 loser waits for release and rearbitration", (first == 0) ? dt : ct, 5);
    chk("R9 no simultaneous acks", {31'h0, both}, 32'h0);
    chk("R9 loser rdata zero at winner ack", lose_rd, 32'h0);
    chk("R6 cpu read slave0 word0", crd, 32'hBEEF_0000);
    chk("R6 dsp read slave1 word3", drd, 32'hBEEF_0103);
  endtask

  task automatic t_reg_access();
    logic [31:0] rd; int lat;
    do_xfer(0, 1'b1, 32'h8000_0024, 32'hA5A5_0F0F, rd, lat);
    chk("R2 single master latency", lat, 2);
    chk("R6 select slave2", 32'(sn_sel), 32'h04);
    chk("R6 reg word index", 32'(sn_reg), 32'h1);
    chk("R10 write strobe", {30'h0, sn_rd, sn_wr}, 32'h1);
    chk("R10 write data", sn_wd, 32'hA5A5_0F0F);
    chk("R9 other ack low", {31'h0, oth_ack}, 32'h0);
    do_xfer(1, 1'b0, 32'h8000_0024, 32'h0, rd, lat);
    chk("R10 read strobe", {30'h0, sn_rd, sn_wr}, 32'h2);
    chk("R6 read back slave2", rd, 32'hA5A5_0F0F);
    chk("R9 other rdata zero", oth_rd, 32'h0);
  endtask

  task automatic t_mem_access();
    logic [31:0] rd; int lat;
    do_xfer(1, 1'b1, 32'h0040_0010, 32'h3C3C_1234, rd, lat);
    chk("R7 select memory", 32'(sn_sel), 32'h10);
    chk("R7 memory word address", 32'(sn_mem), 32'h4);
    chk("R10 dsp write data", sn_wd, 32'h3C3C_1234);
    do_xfer(0, 1'b0, 32'h0040_0010, 32'h0, rd, lat);
    chk("R7 memory read back", rd, 32'h3C3C_1234);
    chk("R2 memory latency", lat, 2);
  endtask

  task automatic t_unmapped();
    logic [31:0] rd; int lat;
    do_xfer(0, 1'b0, 32'h8000_0050, 32'h0, rd, lat);
    chk("R8 index past NREG no select", 32'(sn_sel), 32'h0);
    chk("R8 immediate ack", lat, 1);
    chk("R8 zero data", rd, 32'h0);
    do_xfer(1, 1'b1, 32'h1000_0000, 32'hFFFF_FFFF, rd, lat);
    chk("R8 outside all regions no select", 32'(sn_sel), 32'h0);
    chk("R8 write ack", lat, 1);
  endtask

  task automatic t_rotation();
    logic [31:0] rd; int lat;
    do_xfer(0, 1'b0, 32'h8000_0000, 32'h0, rd, lat);
    chk("R2 cpu alone granted", lat, 2);
    t_contend(1, "R4 display after cpu served");
    do_xfer(1, 1'b0, 32'h8000_0000, 32'h0, rd, lat);
    chk("R2 dsp alone granted", lat, 2);
    t_contend(0, "R4 cpu after display served");
  endtask

  initial begin
    t_reset();
    t_contend(0, "R3 cpu first after reset");
    t_reg_access();
    t_mem_access();
    t_unmapped();
    t_rotation();
    repeat (3) @(negedge clk);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
  end
endmodule